// File: doc/BRIEF.md
# Interrupt Flag Register Bank

This block collects a parameterised number of interrupt sources and presents them to software through a small register window. Each source can be captured in one of two ways. In edge mode a rising edge on the source sets a sticky flag that software must clear. In level mode the reported flag tracks the raw input, so software has to quiet the source itself. Software can also force flags to test its interrupt handler, enable individual sources, and read the raw inputs without side effects.

A single interrupt pin is driven from a register. It is asserted when any reported flag has its enable bit set. A build-time parameter selects whether the pin is asserted high or low. The register port is a plain single-cycle write strobe with a combinational read, and it is meant to sit behind whatever bus adapter the surrounding chip uses.

Top module: `irq_flag_bank`

## Requirements
- R1: While reset is asserted and after it is released, all latched flags, edge-history bits, enable bits and mode bits read 0, and the pin is inactive: 0 when active-high, 1 when active-low.
- R2: For a source in edge mode (mode bit 0), if the input is 1 at a clock edge and was 0 at the previous edge (history is 0 after reset), the flag at address 0 reads 1 after that edge. An input that stays high does not set the flag again once it has been cleared.
- R3: Address 0 holds the flags and is write-1-to-clear. A write sets a latched flag to 0 wherever the write data bit is 1 and leaves the flag unchanged wherever the bit is 0.
- R4: When a set event (a rising edge or a generate write) and a clear occur for the same source on the same clock edge, the flag ends up set.
- R5: Address 3 is the generate register. Writing a 1 sets the matching latched flag at that clock edge. The address always reads 0.
- R6: Address 4 is read-only and returns the current raw inputs. Writes to it have no effect.
- R7: For a source in level mode (mode bit 1), the flag read at address 0 equals the live input in the same cycle. A clear write leaves it at 1 while the input stays 1.
- R8: Address 1 (enable) and address 2 (mode) are read/write registers, one bit per source.
- R9: The pin is registered. After each clock edge, it is asserted exactly when the OR over sources of (reported flag AND enable bit), taken before that edge, is 1.
- R10: With the polarity parameter at 0, the pin is the inverse of the active-high pin under the same stimulus.
- R11: Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | N_SRC | Raw interrupt inputs |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Combinational read data for bus_addr |
| irq_pin | output | 1 | Registered interrupt pin, polarity set by PIN_ACT_HIGH |

## Verification
The hardest case to reach from the ports is a clear that lands on the same clock edge as a fresh rising edge on the same source, because the write strobe and the input transition must line up on one edge. The stimulus table drives the new input level and a clear write to address 0 in the same half-cycle, so both are sampled together. The table also keeps an input high across a later clear, which shows that no edge is seen again. Level mode is checked with a separate directed step: a clear write is issued while the level input is still high, and the flag is read back afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FLAG = 3'd0,
    SEL_EN   = 3'd1,
    SEL_MODE = 3'd2,
    SEL_GEN  = 3'd3,
    SEL_LIVE = 3'd4
  } reg_sel_e;

  // next value of one latched flag: a set event beats a clear
  function automatic logic next_latch(logic cur, logic set_ev, logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction

  // rising edge seen against the previous sample
  function automatic logic rise(logic now_v, logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic level_mode,
  input  logic force_set,
  input  logic clr,
  output logic set_evt,
  output logic latch_q,
  output logic rep
);
  import irq_pkg::*;

  logic hist_q;

  assign set_evt = rise(src, hist_q) | force_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      hist_q  <= src;
      latch_q <= next_latch(latch_q, set_evt, clr);
    end
  end

  assign rep = level_mode ? src : latch_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int N_SRC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [irq_pkg::ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]          bus_wdata,
  input  logic [N_SRC-1:0]          rep_flags,
  input  logic [N_SRC-1:0]          live,
  output logic [N_SRC-1:0]          en_q,
  output logic [N_SRC-1:0]          mode_q,
  output logic [N_SRC-1:0]          force_v,
  output logic [N_SRC-1:0]          clr_v,
  output logic [N_SRC-1:0]          bus_rdata
);
  import irq_pkg::*;

  logic wr_flag, wr_en, wr_mode, wr_gen;

  assign wr_flag = bus_wr && (bus_addr == SEL_FLAG);
  assign wr_en   = bus_wr && (bus_addr == SEL_EN);
  assign wr_mode = bus_wr && (bus_addr == SEL_MODE);
  assign wr_gen  = bus_wr && (bus_addr == SEL_GEN);

  assign clr_v   = wr_flag ? bus_wdata : '0;
  assign force_v = wr_gen  ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      if (wr_en)   en_q   <= bus_wdata;
      if (wr_mode) mode_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      SEL_FLAG: bus_rdata = rep_flags;
      SEL_EN:   bus_rdata = en_q;
      SEL_MODE: bus_rdata = mode_q;
      SEL_LIVE: bus_rdata = live;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int N_SRC        = 8,
  parameter bit PIN_ACT_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rep_flags,
  input  logic [N_SRC-1:0] en_q,
  output logic             pin_q,
  output logic             irq_pin
);
  function automatic logic any_pending(logic [N_SRC-1:0] f, logic [N_SRC-1:0] e);
    return |(f & e);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= any_pending(rep_flags, en_q);
  end

  generate
    if (PIN_ACT_HIGH) begin : g_hi
      assign irq_pin = pin_q;
    end else begin : g_lo
      assign irq_pin = ~pin_q;
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N_SRC        = 8,
  parameter bit PIN_ACT_HIGH = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SRC-1:0]           src_in,
  input  logic                       bus_wr,
  input  logic [irq_pkg::ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]           bus_wdata,
  output logic [N_SRC-1:0]           bus_rdata,
  output logic                       irq_pin
);
  logic [N_SRC-1:0] en_q, mode_q, force_v, clr_v;
  logic [N_SRC-1:0] set_evt, latch_q, rep_flags;
  logic             pin_q;

  irq_regfile #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rep_flags(rep_flags), .live(src_in),
    .en_q(en_q), .mode_q(mode_q), .force_v(force_v), .clr_v(clr_v),
    .bus_rdata(bus_rdata)
  );

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_src_cell u_cell (
        .clk(clk), .rst_n(rst_n), .src(src_in[i]), .level_mode(mode_q[i]),
        .force_set(force_v[i]), .clr(clr_v[i]), .set_evt(set_evt[i]),
        .latch_q(latch_q[i]), .rep(rep_flags[i])
      );
    end
  endgenerate

  irq_pin_drv #(.N_SRC(N_SRC), .PIN_ACT_HIGH(PIN_ACT_HIGH)) u_pin (
    .clk(clk), .rst_n(rst_n), .rep_flags(rep_flags), .en_q(en_q),
    .pin_q(pin_q), .irq_pin(irq_pin)
  );
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
  parameter int N_SRC = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_SRC-1:0]           src_in,
  input logic [irq_pkg::ADDR_W-1:0] bus_addr,
  input logic [N_SRC-1:0]           bus_rdata,
  input logic [N_SRC-1:0]           set_evt,
  input logic [N_SRC-1:0]           clr_v,
  input logic [N_SRC-1:0]           latch_q,
  input logic [N_SRC-1:0]           mode_q,
  input logic [N_SRC-1:0]           en_q,
  input logic [N_SRC-1:0]           rep_flags,
  input logic                       pin_q
);
  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (latch_q == '0 && pin_q == 1'b0));

  // R2 and R4: any set event leaves its flag set, even with a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((latch_q & $past(set_evt)) == $past(set_evt)));

  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_v & ~set_evt)) |=> ((latch_q & $past(clr_v & ~set_evt)) == '0));

  p_gen_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == irq_pkg::SEL_GEN) |-> (bus_rdata == '0));

  p_live_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == irq_pkg::SEL_LIVE) |-> (bus_rdata == src_in));

  p_level_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == irq_pkg::SEL_FLAG) && (|mode_q)) |-> ((bus_rdata & mode_q) == (src_in & mode_q)));

  p_pin_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) || (pin_q == $past(|(rep_flags & en_q))));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .set_evt(set_evt), .clr_v(clr_v),
  .latch_q(latch_q), .mode_q(mode_q), .en_q(en_q),
  .rep_flags(rep_flags), .pin_q(pin_q)
);

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_in;
  logic         bus_wr;
  logic [2:0]   bus_addr;
  logic [N-1:0] bus_wdata;
  logic [N-1:0] bus_rdata, rdata_lo;
  logic         irq_pin, pin_lo;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_flag_bank #(.N_SRC(N), .PIN_ACT_HIGH(1'b1)) i_irq_flag_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin)
  );

  irq_flag_bank #(.N_SRC(N), .PIN_ACT_HIGH(1'b0)) i_irq_flag_bank_lo (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_lo),
    .irq_pin(pin_lo)
  );

  typedef struct packed {
    logic [7:0] src;
    logic       wr;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp_f;
    logic       exp_pin;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{8'h01, 1'b0, 3'd0, 8'h00, 8'h01, 1'b0},  // R2 edge sets
    '{8'h01, 1'b0, 3'd0, 8'h00, 8'h01, 1'b1},  // R9 pin follows
    '{8'h00, 1'b1, 3'd0, 8'h01, 8'h00, 1'b1},  // R3 clear
    '{8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0},
    '{8'h06, 1'b1, 3'd0, 8'h02, 8'h06, 1'b0},  // R4 edge beats clear
    '{8'h06, 1'b1, 3'd0, 8'h06, 8'h00, 1'b1},  // R2 held high, no re-set
    '{8'h00, 1'b1, 3'd3, 8'h80, 8'h80, 1'b0},  // R5 generate
    '{8'h00, 1'b1, 3'd0, 8'h00, 8'h80, 1'b1},  // R3 zero writes keep
    '{8'h00, 1'b1, 3'd0, 8'h80, 8'h00, 1'b1},  // R3 clear forced flag
    '{8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    #12;
    // R1 state during reset
    rd(3'd0, d); check("R1 flags", d, 8'h00);
    rd(3'd1, d); check("R1 enable", d, 8'h00);
    rd(3'd2, d); check("R1 mode", d, 8'h00);
    check("R1 pin high-active", {7'b0, irq_pin}, 8'h00);
    check("R1 pin low-active", {7'b0, pin_lo}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 pin after release", {7'b0, irq_pin}, 8'h00);

    wr(3'd1, 8'hFF);
    rd(3'd1, d); check("R8 enable readback", d, 8'hFF);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      src_in = TBL[k].src; bus_wr = TBL[k].wr;
      bus_addr = TBL[k].addr; bus_wdata = TBL[k].wdata;
      @(posedge clk);
      #1 bus_wr = 1'b0; bus_addr = 3'd0;
      #1;
      check($sformatf("R2/R3/R4/R5 flags row %0d", k), bus_rdata, TBL[k].exp_f);
      check($sformatf("R9 pin row %0d", k), {7'b0, irq_pin}, {7'b0, TBL[k].exp_pin});
      check($sformatf("R10 low pin row %0d", k), {7'b0, pin_lo}, {7'b0, ~TBL[k].exp_pin});
    end

    // R5 generate address reads 0
    rd(3'd3, d); check("R5 gen reads 0", d, 8'h00);

    // R6 live inputs and ignored write
    @(negedge clk); src_in = 8'h5A;
    rd(3'd4, d); check("R6 live", d, 8'h5A);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check("R6 live after write", d, 8'h5A);
    wr(3'd0, 8'hFF);  // drop edge flags from 5A
    @(negedge clk); src_in = 8'h00;
    @(posedge clk); #1;
    rd(3'd0, d); check("R6 flags cleared", d, 8'h00);

    // R11 unmapped addresses
    wr(3'd6, 8'h00);
    rd(3'd1, d); check("R11 enable untouched", d, 8'hFF);
    rd(3'd5, d); check("R11 addr5 reads 0", d, 8'h00);
    rd(3'd7, d); check("R11 addr7 reads 0", d, 8'h00);

    // R8 mode register, R7 level mode on source 4
    wr(3'd2, 8'h10);
    rd(3'd2, d); check("R8 mode readback", d, 8'h10);
    @(negedge clk); src_in = 8'h10;
    rd(3'd0, d); check("R7 level follows input", d, 8'h10);
    @(posedge clk); #2;
    check("R9 pin from level", {7'b0, irq_pin}, 8'h01);
    wr(3'd0, 8'h10);
    rd(3'd0, d); check("R7 clear no lasting effect", d, 8'h10);
    @(negedge clk); src_in = 8'h00;
    rd(3'd0, d); check("R7 level drops with input", d, 8'h00);
    @(posedge clk); #2;
    check("R9 pin drops", {7'b0, irq_pin}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule